// File: doc/BRIEF.md
# Key Schedule Expander (128-bit key to 52 subkeys)

This block turns a 128-bit user key into the 52 sixteen-bit subkeys used by a block cipher's encryption rounds. After a start strobe it captures the key into a 128-bit rotating register. It then emits one subkey per clock cycle through a simple write port (index, data, write enable) so that a register file or small memory next to the cipher datapath can be filled in index order.

Subkeys come in batches of eight. Each subkey is a 16-bit slice of the register, taken from the most significant end downwards. Between batches the whole register rotates left by 25 bits, so every slice joins the low 7 bits of one word to the high 9 bits of the next. The last batch stops after four slices. The block reports busy while it writes and raises done for one cycle when it has finished.

Top module: `keysched_expander`

## Requirements
- R1: While the reset is applied, and right after it, busy, done and wr_en are all 0.
- R2: A start seen while idle begins an expansion. In the next cycle wr_en goes high with wr_idx = 0. wr_idx then rises by 1 every cycle, with wr_en held high.
- R3: Subkeys 0 to 7 are the captured key cut into 16-bit words from the most significant end: subkey i = key[127-16i : 112-16i].
- R4: For batch b (b = 1..6), subkey 8b+i equals bits [127-16i : 112-16i] of the captured key rotated left by 25*b bits.
- R5: Exactly 52 writes occur (indices 0..51). The last batch holds only indices 48..51, and wr_en is 0 in the cycle after index 51.
- R6: busy is high in every write cycle. In the cycle after index 51, done is 1 and busy is 0. In the cycle after that, done is 0.
- R7: A start asserted while busy is ignored: the index sequence and the written data go on unchanged.
- R8: The key is sampled only on the accepted start. Changes on key_in during an expansion do not affect any subkey.
- R9: A start asserted in the done cycle is accepted and begins a new expansion with the key present in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begin an expansion (ignored while busy) |
| key_in | input | 128 | User key, sampled on an accepted start |
| busy | output | 1 | Expansion in progress |
| done | output | 1 | One-cycle pulse after the last subkey is written |
| wr_en | output | 1 | Subkey write enable |
| wr_idx | output | 6 | Subkey index 0..51 |
| wr_data | output | 16 | Subkey value |

## Verification
The bench compares all 52 subkeys for several keys, including all-zero, all-ones and single-bit-set patterns. These show whether the rotation amount or direction is wrong, or whether the slices are taken from the wrong end: either fault corrupts batch 1 onwards, or batch 0 as well. It checks that the run ends after index 51. A design that ran a full last batch would keep wr_en high or give done late. It also injects a second start and a changed key in the middle of a run; a design that reloaded would restart at index 0 or emit the new key's slices. A chained start in the done cycle checks that a back-to-back restart is not lost.

// File: rtl/keysched_pkg.sv
package keysched_pkg;
  localparam int KS_KEY_W   = 128;
  localparam int KS_SUB_W   = 16;
  localparam int KS_NUM_SUB = 52;
  localparam int KS_ROT     = 25;
  localparam int KS_SYNC    = 2;
endpackage

// File: rtl/ks_rst_sync.sv
module ks_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ks_key_reg.sv
module ks_key_reg #(
  parameter int KEY_W = 128,
  parameter int ROT   = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             rotate,
  input  logic [KEY_W-1:0] key_in,
  output logic [KEY_W-1:0] key_q
);
  logic [KEY_W-1:0] key_d;
  logic [KEY_W-1:0] key_rot;
  logic             key_en;

  assign key_rot = {key_q[KEY_W-1-ROT:0], key_q[KEY_W-1:KEY_W-ROT]};

  always_comb begin
    key_en = load | rotate;
    if (load) key_d = key_in;
    else      key_d = key_rot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      key_q <= '0;
    else if (key_en) key_q <= key_d;
  end

  // R3
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> key_q == $past(key_in));

  // R4
  rotate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate && !load) |=> key_q == {$past(key_q[KEY_W-1-ROT:0]), $past(key_q[KEY_W-1:KEY_W-ROT])});

  // R8
  key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !rotate) |=> $stable(key_q));
endmodule

// File: rtl/ks_slice_mux.sv
module ks_slice_mux #(
  parameter int KEY_W  = 128,
  parameter int SUB_W  = 16,
  parameter int LANES  = KEY_W / SUB_W,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic [KEY_W-1:0]  key_q,
  input  logic [LANE_W-1:0] lane,
  output logic [SUB_W-1:0]  slice
);
  logic [SUB_W-1:0] slices [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign slices[l] = key_q[KEY_W-1-SUB_W*l -: SUB_W];
  end

  always_comb begin
    slice = '0;
    for (int l = 0; l < LANES; l++) begin
      if (lane == LANE_W'(l)) slice = slices[l];
    end
  end
endmodule

// File: rtl/ks_ctrl.sv
module ks_ctrl #(
  parameter int NUM_SUB = 52,
  parameter int LANES   = 8,
  parameter int IDX_W   = $clog2(NUM_SUB),
  parameter int LANE_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              wr_en,
  output logic [IDX_W-1:0]  idx,
  output logic [LANE_W-1:0] lane,
  output logic              load,
  output logic              rotate
);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NUM_SUB - 1);
  localparam logic [IDX_W-1:0]  LANES_IDX = IDX_W'(LANES);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             accept;
  logic             last;

  always_comb begin
    lane   = LANE_W'(idx_q % LANES_IDX);
    accept = start && !busy_q;
    last   = busy_q && (idx_q == LAST_IDX);
    busy_d = busy_q;
    idx_d  = idx_q;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (last) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      idx_d = idx_q + IDX_W'(1);
    end
    done_d = last;
    load   = accept;
    rotate = busy_q && !last && (lane == LAST_LANE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign wr_en = busy_q;
  assign idx   = idx_q;

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && idx_q != LAST_IDX) |=> (busy_q && idx_q == $past(idx_q) + IDX_W'(1)));

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> idx_q <= LAST_IDX);

  // R6
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q) && $past(idx_q) == LAST_IDX));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && idx_q != LAST_IDX) |=> idx_q != '0);
endmodule

// File: rtl/keysched_expander.sv
module keysched_expander
  import keysched_pkg::*;
#(
  parameter int KEY_W   = KS_KEY_W,
  parameter int SUB_W   = KS_SUB_W,
  parameter int NUM_SUB = KS_NUM_SUB,
  parameter int ROT     = KS_ROT,
  parameter int SYNC    = KS_SYNC,
  parameter int IDX_W   = $clog2(NUM_SUB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [KEY_W-1:0] key_in,
  output logic             busy,
  output logic             done,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [SUB_W-1:0] wr_data
);
  localparam int LANES  = KEY_W / SUB_W;
  localparam int LANE_W = $clog2(LANES);

  logic              rst_n_sync;
  logic              load;
  logic              rotate;
  logic [LANE_W-1:0] lane;
  logic [KEY_W-1:0]  key_q;

  ks_rst_sync #(.STAGES(SYNC)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  ks_ctrl #(
    .NUM_SUB (NUM_SUB),
    .LANES   (LANES),
    .IDX_W   (IDX_W),
    .LANE_W  (LANE_W)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .wr_en  (wr_en),
    .idx    (wr_idx),
    .lane   (lane),
    .load   (load),
    .rotate (rotate)
  );

  ks_key_reg #(
    .KEY_W (KEY_W),
    .ROT   (ROT)
  ) u_key (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .load   (load),
    .rotate (rotate),
    .key_in (key_in),
    .key_q  (key_q)
  );

  ks_slice_mux #(
    .KEY_W  (KEY_W),
    .SUB_W  (SUB_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_mux (
    .key_q (key_q),
    .lane  (lane),
    .slice (wr_data)
  );

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (done && start) |=> (busy && wr_idx == '0));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !busy |-> !wr_en);
endmodule

// File: tb/keysched_expander_test.sv
module keysched_expander_test;
  localparam int CLK_PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [127:0] key_in;
  logic         busy, done, wr_en;
  logic [5:0]   wr_idx;
  logic [15:0]  wr_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  keysched_expander uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .key_in  (key_in),
    .busy    (busy),
    .done    (done),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] model_sub(input logic [127:0] k, input int i);
    logic [127:0] r;
    int b, l;
    b = i / 8;
    l = i % 8;
    r = k;
    for (int s = 0; s < 25 * b; s++) r = {r[126:0], r[127]};
    return r[127-16*l -: 16];
  endfunction

  task automatic check(input string req, input bit ok, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; key_in = '0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy == 1'b0, busy, 0);
    check("R1 done in reset", done == 1'b0, done, 0);
    check("R1 wr_en in reset", wr_en == 1'b0, wr_en, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", {busy, done, wr_en} == 3'b000, {busy, done, wr_en}, 0);
  endtask

  // Runs one expansion of key k and checks every write.
  // prestarted: start was already accepted by the caller.
  // poke_at >= 0: a start with poke_key is driven during write poke_at (R7, R8).
  // chain: a start with next_key is driven in the done cycle (R9).
  task automatic t_expand(input logic [127:0] k, input bit prestarted,
                          input int poke_at, input logic [127:0] poke_key,
                          input bit chain, input logic [127:0] next_key);
    int bad_data = 0;
    int bad_idx  = 0;
    if (!prestarted) begin
      start = 1'b1; key_in = k;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 52; i++) begin
      logic [15:0] e;
      e = model_sub(k, i);
      if (!(wr_en && busy && wr_idx == 6'(i))) begin
        bad_idx++;
        check("R2 index/busy sequence", 1'b0, {wr_en, busy, wr_idx}, {2'b11, 6'(i)});
      end
      if (wr_data !== e) begin
        bad_data++;
        if (i < 8) check("R3 first batch subkey", 1'b0, wr_data, e);
        else if (poke_at >= 0) check("R8 subkey after key change", 1'b0, wr_data, e);
        else check("R4 rotated subkey", 1'b0, wr_data, e);
      end
      start = 1'b0;
      if (i == poke_at) begin
        start = 1'b1; key_in = poke_key;
      end
      @(negedge clk);
    end
    if (poke_at >= 0) begin
      check("R7 run unaffected by start while busy", bad_idx == 0, bad_idx, 0);
      check("R8 data unaffected by key change", bad_data == 0, bad_data, 0);
    end else begin
      check("R2 all indices in order", bad_idx == 0, bad_idx, 0);
      check("R3/R4 all 52 subkeys match", bad_data == 0, bad_data, 0);
    end
    check("R5 wr_en low after index 51", wr_en == 1'b0, wr_en, 0);
    check("R6 done after last write", done == 1'b1 && busy == 1'b0, {done, busy}, 2'b10);
    if (chain) begin
      start = 1'b1; key_in = next_key;
      @(negedge clk);
      start = 1'b0;
      check("R9 restart from done cycle", busy == 1'b1 && wr_idx == 6'd0 && done == 1'b0,
            {busy, done, wr_idx}, {2'b10, 6'd0});
    end else begin
      @(negedge clk);
      check("R6 done lasts one cycle", done == 1'b0 && busy == 1'b0, {done, busy}, 0);
    end
  endtask

  initial begin
    t_reset();
    t_expand(128'h0001_0002_0003_0004_0005_0006_0007_0008, 0, -1, '0, 0, '0);
    t_expand(128'h8000_0000_0000_0000_0000_0000_0000_0001, 0, -1, '0, 0, '0);
    t_expand('0, 0, -1, '0, 0, '0);
    t_expand({128{1'b1}}, 0, -1, '0, 0, '0);
    t_expand(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 0, 20,
             128'hDEAD_BEEF_CAFE_F00D_1234_5678_9ABC_DEF0, 0, '0);
    t_expand(128'h2B7E_1516_28AE_D2A6_ABF7_1588_09CF_4F3C, 0, -1, '0, 1,
             128'h5A5A_A5A5_0F0F_F0F0_3C3C_C3C3_6969_9696);
    t_expand(128'h5A5A_A5A5_0F0F_F0F0_3C3C_C3C3_6969_9696, 1, -1, '0, 0, '0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule